// File: doc/BRIEF.md
# Write-only serial clock-enable controller

This block lets a two-wire (I2C) bus master switch ten buffered copies of a reference clock on and off. It is a receive-only slave. SCL and SDA reach it already synchronized to a faster system clock, and it samples them there. The block detects START and STOP conditions and shifts each byte in MSB first. It answers only its own 7-bit address in write direction, and it pulls SDA low to acknowledge bytes.

The two bytes that follow the address are accepted and thrown away. The next three bytes load the per-output enable bits. Each enable bit either passes the reference clock to its output or holds that output low. An active-low output-enable pin takes priority over the enable bits: when it is low, every output pad is released to high impedance. The port `clk_drv` carries the pad drive enable for this.

Top module: `clkbuf_enable_slave`

## Requirements
- R1: After reset all ten enable bits are 1: with `oe_n`=1 every `clk_out` bit equals `ref_clk` and every `clk_drv` bit is 1.
- R2: A first byte of 1101001 followed by R/W=0 is acknowledged. `sda_pull` is high from the SCL fall after the 8th bit until the SCL fall after the 9th bit, and it changes only while SCL is low.
- R3: A first byte with a different address, or with R/W=1, is not acknowledged. No later byte of that transfer is acknowledged, and no enable bit changes.
- R4: The 1st and 2nd bytes after the address are acknowledged and have no effect on any output.
- R5: The 3rd byte after the address, received MSB first, loads its bits 3..0 into the enables of outputs 3..0. Its bits 7..4 have no effect.
- R6: The 4th byte after the address loads its bits 7..4 into the enables of outputs 7..4. Its bits 3..0 have no effect.
- R7: The 5th byte after the address loads bit 7 into the enable of output 9 and bit 6 into the enable of output 8. Bits 5..0 have no effect.
- R8: An output whose enable bit is 0 is held at 0. No output is ever 1 while `ref_clk` is 0.
- R9: With `oe_n`=0 all `clk_drv` bits are 0 and all `clk_out` bits are 0, whatever the enables hold. With `oe_n`=1 all `clk_drv` bits are 1.
- R10: Bytes after the 5th byte following the address are acknowledged and change nothing.
- R11: A STOP or a repeated START returns the block to the address phase and releases `sda_pull`. Enables already written keep their values, and a byte cut short is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data (wired bus level) |
| sda_pull | output | 1 | 1 drives SDA low (acknowledge) |
| ref_clk | input | 1 | Reference clock to be distributed |
| oe_n | input | 1 | Active-low output enable for all pads |
| clk_out | output | 10 | Gated clock value per output |
| clk_drv | output | 10 | Pad drive enable per output; 0 means high impedance |

## Verification
The acknowledge-timing properties assume a well-formed bus. SCL has to stay low for several system clocks around each falling edge. SDA changes only while SCL is low, except for START and STOP. The master never issues a STOP during a slave acknowledge. The bench drives the bus in quarter-bit steps of four system clocks, and it changes SDA only in the low phase of SCL apart from the explicit START and STOP tasks. It releases SDA during each ninth clock, so the properties always see legal traffic.

// File: rtl/clkbuf_enable_slave.sv
module clkbuf_enable_slave #(
  parameter logic [6:0] DEV_ADDR   = 7'h69,
  parameter int         SKIP_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  input  logic       ref_clk,
  input  logic       oe_n,
  output logic [9:0] clk_out,
  output logic [9:0] clk_drv
);
  localparam int NUM_OUT = 10;
  localparam int LAST_I  = SKIP_BYTES + 4;
  localparam int IDX_W   = $clog2(LAST_I + 1);
  localparam logic [IDX_W-1:0] IDX_D0   = IDX_W'(SKIP_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_D1   = IDX_W'(SKIP_BYTES + 2);
  localparam logic [IDX_W-1:0] IDX_D2   = IDX_W'(SKIP_BYTES + 3);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LAST_I);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACKWAIT, S_ACK, S_SKIP} st_t;

  st_t              st;
  logic             scl_q, sda_q, ack_pend;
  logic [2:0]       bit_cnt;
  logic [6:0]       shreg;
  logic [IDX_W-1:0] idx;
  logic [NUM_OUT-1:0] en;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire bus_start = scl_i & scl_q & sda_q & ~sda_i;
  wire bus_stop  = scl_i & scl_q & ~sda_q & sda_i;
  wire [7:0] rx_byte = {shreg, sda_i};
  wire addr_ok = (rx_byte[7:1] == DEV_ADDR) && !rx_byte[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      st       <= S_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      idx      <= '0;
      ack_pend <= 1'b0;
      sda_pull <= 1'b0;
      en       <= '1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (bus_start) begin
        st       <= S_RX;
        bit_cnt  <= '0;
        idx      <= '0;
        sda_pull <= 1'b0;
      end else if (bus_stop) begin
        st       <= S_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            shreg   <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              st       <= S_ACKWAIT;
              ack_pend <= (idx != '0) || addr_ok;
              if (idx == IDX_D0) en[3:0] <= rx_byte[3:0];
              if (idx == IDX_D1) en[7:4] <= rx_byte[7:4];
              if (idx == IDX_D2) en[9:8] <= rx_byte[7:6];
            end
          end
          S_ACKWAIT: if (scl_fall) begin
            if (ack_pend) begin
              sda_pull <= 1'b1;
              st       <= S_ACK;
            end else begin
              st <= S_SKIP;
            end
          end
          S_ACK: if (scl_fall) begin
            sda_pull <= 1'b0;
            st       <= S_RX;
            if (idx != IDX_LAST) idx <= idx + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign clk_drv = {NUM_OUT{oe_n}};
  assign clk_out = oe_n ? (en & {NUM_OUT{ref_clk}}) : '0;
endmodule

// File: rtl/clkbuf_enable_slave_chk.sv
module clkbuf_enable_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_pull,
  input logic       ref_clk,
  input logic       oe_n,
  input logic [9:0] clk_out,
  input logic [9:0] clk_drv
);
  // R2
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_i);

  // R2
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_i);

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !sda_pull);

  // R8
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out & ~{10{ref_clk}}) == 10'd0);

  // R9
  hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (clk_out == 10'd0 && clk_drv == 10'd0));
endmodule

bind clkbuf_enable_slave clkbuf_enable_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_pull(sda_pull), .ref_clk(ref_clk), .oe_n(oe_n),
  .clk_out(clk_out), .clk_drv(clk_drv)
);

// File: tb/clkbuf_enable_slave_tb.sv
`timescale 1ns/1ps
module clkbuf_enable_slave_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic ref_clk = 1'b0, oe_n = 1'b1;
  logic sda_pull;
  logic [9:0] clk_out, clk_drv;
  logic [9:0] exp_en = '1;
  int n_vec = 0, n_bad = 0;

  wire sda_bus = sda_m & ~sda_pull;

  always #10 clk = ~clk;

  clkbuf_enable_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull(sda_pull), .ref_clk(ref_clk), .oe_n(oe_n),
    .clk_out(clk_out), .clk_drv(clk_drv)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quarter();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_out(input string req);
    ref_clk = 1'b1; #1;
    chk(req, 16'(clk_out), 16'(exp_en & {10{oe_n}}));
    chk(req, 16'(clk_drv), 16'({10{oe_n}}));
    ref_clk = 1'b0; #1;
    chk(req, 16'(clk_out), 16'd0);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; quarter();
    scl_m = 1'b1; quarter();
    sda_m = 1'b0; quarter();
    scl_m = 1'b0; quarter();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; quarter();
    scl_m = 1'b1; quarter();
    sda_m = 1'b1; quarter();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; quarter();
    scl_m = 1'b1; quarter(); quarter();
    scl_m = 1'b0; quarter();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; quarter();
    scl_m = 1'b1; quarter();
    ack = ~sda_bus;
    quarter();
    scl_m = 1'b0; quarter();
  endtask

  task automatic t_reset();
    chk_out("R1 reset state");
  endtask

  task automatic t_full_write();
    logic a;
    bus_start();
    send_byte({7'b1101001, 1'b0}, a); chk("R2 address ack", 16'(a), 16'd1);
    send_byte(8'hFF, a); chk("R4 command ack", 16'(a), 16'd1);
    send_byte(8'h00, a); chk("R4 count ack", 16'(a), 16'd1);
    chk_out("R4 dummy bytes no effect");
    send_byte(8'hF5, a); chk("R5 data0 ack", 16'(a), 16'd1);
    exp_en[3:0] = 4'b0101;
    chk_out("R5 data0 low nibble, high nibble ignored");
    send_byte(8'h5A, a); chk("R6 data1 ack", 16'(a), 16'd1);
    exp_en[7:4] = 4'b0101;
    chk_out("R6 data1 high nibble");
    send_byte(8'h7F, a); chk("R7 data2 ack", 16'(a), 16'd1);
    exp_en[9:8] = 2'b01;
    chk_out("R7 data2 top bits, R8 disabled held low");
    send_byte(8'h00, a); chk("R10 extra byte ack", 16'(a), 16'd1);
    send_byte(8'hFF, a); chk("R10 extra byte ack", 16'(a), 16'd1);
    bus_stop();
    chk_out("R10 extra bytes ignored");
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    send_byte({7'b1101000, 1'b0}, a); chk("R3 wrong address nack", 16'(a), 16'd0);
    send_byte(8'h00, a); chk("R3 later byte nack", 16'(a), 16'd0);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    bus_stop();
    chk_out("R3 wrong address no change");
    bus_start();
    send_byte({7'b1101001, 1'b1}, a); chk("R3 read request nack", 16'(a), 16'd0);
    send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'h00, a);
    bus_stop();
    chk_out("R3 read request no change");
  endtask

  task automatic t_oe();
    oe_n = 1'b0; #1;
    chk_out("R9 oe low forces high-z");
    oe_n = 1'b1; #1;
    chk_out("R9 oe high restores");
  endtask

  task automatic t_restart();
    logic a;
    bus_start();
    send_byte({7'b1101001, 1'b0}, a);
    send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h0F, a);
    exp_en[3:0] = 4'hF;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    chk_out("R11 partial byte after stop discarded");
    bus_start();
    send_byte({7'b1101001, 1'b0}, a);
    send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h00, a);
    exp_en[3:0] = 4'h0;
    bus_start();
    send_byte({7'b1101001, 1'b0}, a); chk("R11 repeated start address ack", 16'(a), 16'd1);
    send_byte(8'h00, a); send_byte(8'h00, a);
    chk_out("R11 written value kept across restart");
    send_byte(8'h0C, a); send_byte(8'hF0, a); send_byte(8'hC0, a);
    exp_en = 10'b11_1111_1100;
    bus_stop();
    chk_out("R11 writes after restart land in data0..2");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_full_write();
    t_wrong_addr();
    t_oe();
    t_restart();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end
endmodule